// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block holds the software-visible state of a single DMA channel. It contains four 32-bit registers: a control/status word, a transfer address, a byte count and a high-order address. A word-only bus reaches them. Only address bits 3:2 select a register, so the set of four repeats every 16 bytes across the decoded window. Reads are combinational. Writes take effect at the next clock edge.

The control/status word is the control point for the attached peripheral. Its fixed version field and its interrupt-pending and loaded flags are protected from bus writes. A request level from the device drives the pending flag. The block raises an interrupt whenever pending and enable are both set. It gives the device a one-cycle reset strobe, a DMA-enable level, and rise and fall strobes that mark changes of that level. Writes to the control word are rewritten before they are stored: the drain request is either removed or inserted, depending on the other bits of the write. The device-side transfer engine advances the address register through a dedicated increment port. The transfer engine itself lies outside this block.

Top module: `dmac_regs`

## Requirements
- R1: The register index is bus address bits 3:2. Index 0 is control/status, 1 is address, 2 is count and 3 is high address. Any address with the same bits 3:2 reaches the same register.
- R2: After reset, control/status reads 0xA0000000 and the other three registers read 0. The outputs irq_out, dev_rst_pulse, dev_dma_en, dev_en_rise and dev_en_fall are all low.
- R3: Control/status bit 0 (pending) takes the level of dev_irq_req sampled at each clock edge. It is set when the request is high and cleared when it is low.
- R4: irq_out is high exactly while control/status bit 0 (pending) and bit 4 (interrupt enable) are both set.
- R5: On a control/status write, bits under mask 0xFE000007 keep their previous values, and bits 31 and 29 (value 0xA0000000) always read as one. All other bits take the value of the write after the R7 rewriting.
- R6: A control/status write with bit 7 set produces dev_rst_pulse high for exactly the one cycle after the write edge.
- R7: On a control/status write with bit 7 clear, bit 6 (drain) is removed from the written value. A write of exactly 0 is stored as 0x40. When bit 7 is set, bit 6 is stored as written.
- R8: dev_dma_en equals the stored control/status bit 9. dev_en_rise or dev_en_fall is high for the one cycle after an edge at which the stored bit 9 changes from 0 to 1 or from 1 to 0. Neither strobe fires when bit 9 does not change.
- R9: A write to the address register sets control/status bit 26 (loaded). The bit stays set until reset, including through later control/status writes.
- R10: An access whose bus_be is not 4'b1111 is ignored: a write leaves the register unchanged, and a read returns 0.
- R11: When dev_adv_valid is high, the address register increases by dev_adv_bytes at the clock edge. If a bus write to the address register occurs in the same cycle, the written value is stored and the increment is lost.
- R12: bus_rdata presents the addressed register in the same cycle as the read access, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the register |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| dev_irq_req | input | 1 | Device interrupt request level |
| dev_adv_valid | input | 1 | Device engine advances the address this cycle |
| dev_adv_bytes | input | ADV_W | Number of bytes to add to the address |
| irq_out | output | 1 | Gated interrupt to the host |
| dev_rst_pulse | output | 1 | One-cycle reset strobe to the device |
| dev_dma_en | output | 1 | DMA enable level to the device |
| dev_en_rise | output | 1 | One-cycle strobe when the enable level turns on |
| dev_en_fall | output | 1 | One-cycle strobe when the enable level turns off |

## Verification
The bench targets the rewriting of control/status writes. An all-ones write must keep the protected bits and the drain bit together with the reset request. A write of only the version bits is nonzero and must not receive the inserted drain bit. A plain zero write must become 0x40. A design that tested for zero after masking, or that let the write reach the protected field, would read back a wrong control word or lose the loaded flag. Further cases cover:
- a repeated enable write, which must produce no transition strobe;
- an address write and a device increment in the same cycle, which a reversed priority would turn into the sum;
- partial-word accesses, which a design checking only the strobe for writes would let through on reads;
- aliased addresses above the 16-byte window, which must reach the same registers as the first window.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int REG_W    = 32;
    localparam int NUM_REGS = 4;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int BE_W     = REG_W / 8;

    localparam logic [REG_W-1:0] CSR_VERSION = 32'hA000_0000;
    localparam logic [REG_W-1:0] CSR_RO_MASK = 32'hFE00_0007;

    localparam int CSR_PEND_BIT   = 0;
    localparam int CSR_IEN_BIT    = 4;
    localparam int CSR_DRAIN_BIT  = 6;
    localparam int CSR_RST_BIT    = 7;
    localparam int CSR_EN_BIT     = 9;
    localparam int CSR_LOADED_BIT = 26;

    typedef enum logic [IDX_W-1:0] {
        REG_CSR   = 2'd0,
        REG_ADDR  = 2'd1,
        REG_COUNT = 2'd2,
        REG_HIGH  = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        reg_idx_e         idx;
        logic [REG_W-1:0] data;
    } bus_req_t;

    // Apply the drain rewrite, then merge the result under the protected mask.
    function automatic logic [REG_W-1:0] csr_rewrite(input logic [REG_W-1:0] old_v,
                                                     input logic [REG_W-1:0] wr_v);
        logic [REG_W-1:0] v;
        v = wr_v;
        if (v[CSR_RST_BIT]) begin
            v = wr_v;
        end else if (v[CSR_DRAIN_BIT]) begin
            v[CSR_DRAIN_BIT] = 1'b0;
        end else if (v == '0) begin
            v[CSR_DRAIN_BIT] = 1'b1;
        end
        return (old_v & CSR_RO_MASK) | (v & ~CSR_RO_MASK) | CSR_VERSION;
    endfunction

endpackage

// File: rtl/dmac_bus_decode.sv
module dmac_bus_decode
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output bus_req_t          req
);
    localparam int IDX_LSB = $clog2(BE_W);

    logic full_word;
    logic unused_addr_bits;

    assign full_word        = &bus_be;
    assign unused_addr_bits = ^{bus_addr[ADDR_W-1:IDX_LSB+IDX_W], bus_addr[IDX_LSB-1:0]};

    always_comb begin
        req.wr   = bus_sel && bus_we && full_word;
        req.rd   = bus_sel && !bus_we && full_word;
        req.idx  = reg_idx_e'(bus_addr[IDX_LSB +: IDX_W]);
        req.data = bus_wdata;
    end

endmodule

// File: rtl/dmac_csr.sv
module dmac_csr
    import dmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic             dev_irq_req,
    output logic [REG_W-1:0] csr_q,
    output logic             irq_out,
    output logic             dev_rst_pulse,
    output logic             dev_dma_en,
    output logic             dev_en_rise,
    output logic             dev_en_fall
);
    logic             csr_wr;
    logic             loaded_set;
    logic [REG_W-1:0] csr_d;

    assign csr_wr     = req.wr && (req.idx == REG_CSR);
    assign loaded_set = req.wr && (req.idx == REG_ADDR);

    always_comb begin
        csr_d = csr_q;
        if (csr_wr) begin
            csr_d = csr_rewrite(csr_q, req.data);
        end
        if (loaded_set) begin
            csr_d[CSR_LOADED_BIT] = 1'b1;
        end
        csr_d[CSR_PEND_BIT] = dev_irq_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q         <= CSR_VERSION;
            dev_rst_pulse <= 1'b0;
            dev_en_rise   <= 1'b0;
            dev_en_fall   <= 1'b0;
        end else begin
            csr_q         <= csr_d;
            dev_rst_pulse <= csr_wr && req.data[CSR_RST_BIT];
            dev_en_rise   <= csr_d[CSR_EN_BIT] && !csr_q[CSR_EN_BIT];
            dev_en_fall   <= !csr_d[CSR_EN_BIT] && csr_q[CSR_EN_BIT];
        end
    end

    assign irq_out    = csr_q[CSR_PEND_BIT] && csr_q[CSR_IEN_BIT];
    assign dev_dma_en = csr_q[CSR_EN_BIT];

endmodule

// File: rtl/dmac_addr_reg.sv
module dmac_addr_reg
    import dmac_pkg::*;
#(
    parameter int ADV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             adv_valid,
    input  logic [ADV_W-1:0] adv_bytes,
    output logic [REG_W-1:0] q
);
    localparam int PAD_W = REG_W - ADV_W;

    logic [REG_W-1:0] step;

    generate
        if (PAD_W > 0) begin : g_pad
            assign step = {{PAD_W{1'b0}}, adv_bytes};
        end else begin : g_nopad
            assign step = adv_bytes[REG_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wr_data;
        end else if (adv_valid) begin
            q <= q + step;
        end
    end

endmodule

// File: rtl/dmac_plain_reg.sv
module dmac_plain_reg
    import dmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wr_data;
        end
    end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int ADV_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dev_irq_req,
    input  logic              dev_adv_valid,
    input  logic [ADV_W-1:0]  dev_adv_bytes,
    output logic              irq_out,
    output logic              dev_rst_pulse,
    output logic              dev_dma_en,
    output logic              dev_en_rise,
    output logic              dev_en_fall
);
    bus_req_t         req;
    logic [REG_W-1:0] csr_q;
    logic [REG_W-1:0] reg_q [NUM_REGS];

    dmac_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .req       (req)
    );

    dmac_csr u_csr (
        .clk           (clk),
        .rst           (rst),
        .req           (req),
        .dev_irq_req   (dev_irq_req),
        .csr_q         (csr_q),
        .irq_out       (irq_out),
        .dev_rst_pulse (dev_rst_pulse),
        .dev_dma_en    (dev_dma_en),
        .dev_en_rise   (dev_en_rise),
        .dev_en_fall   (dev_en_fall)
    );

    dmac_addr_reg #(.ADV_W(ADV_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (req.wr && (req.idx == REG_ADDR)),
        .wr_data   (req.data),
        .adv_valid (dev_adv_valid),
        .adv_bytes (dev_adv_bytes),
        .q         (reg_q[REG_ADDR])
    );

    assign reg_q[REG_CSR] = csr_q;

    // Remaining registers carry no side effects.
    generate
        for (genvar g = 2; g < NUM_REGS; g++) begin : g_plain
            dmac_plain_reg u_reg (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (req.wr && (req.idx == reg_idx_e'(g))),
                .wr_data (req.data),
                .q       (reg_q[g])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (req.rd) begin
            bus_rdata = reg_q[req.idx];
        end
    end

endmodule

// File: rtl/dmac_regs_chk.sv
module dmac_regs_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic              dev_irq_req,
    input logic              irq_out,
    input logic              dev_rst_pulse,
    input logic              dev_dma_en,
    input logic              dev_en_rise,
    input logic              dev_en_fall,
    input logic [31:0]       csr_q
);
    logic csr_rst_wr;
    logic unused_chk;

    assign csr_rst_wr = bus_sel && bus_we && (&bus_be) && (bus_addr[3:2] == 2'd0) && bus_wdata[7];
    assign unused_chk = ^{bus_addr[ADDR_W-1:4], bus_addr[1:0]};

    // R6
    rst_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        dev_rst_pulse |=> !dev_rst_pulse);

    // R6
    rst_pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        dev_rst_pulse |-> $past(csr_rst_wr));

    // R8
    en_rise_chk: assert property (@(posedge clk) disable iff (rst)
        dev_en_rise |-> (dev_dma_en && !$past(dev_dma_en)));

    // R8
    en_fall_chk: assert property (@(posedge clk) disable iff (rst)
        dev_en_fall |-> (!dev_dma_en && $past(dev_dma_en)));

    // R8
    en_strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dev_en_rise, dev_en_fall}));

    // R4
    irq_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> $past(dev_irq_req));

    // R9
    loaded_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(csr_q[26]) |-> csr_q[26]);

    // R5
    version_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(csr_q[31:27]) == csr_q[31:27]);

endmodule

bind dmac_regs dmac_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_be        (bus_be),
    .bus_wdata     (bus_wdata),
    .dev_irq_req   (dev_irq_req),
    .irq_out       (irq_out),
    .dev_rst_pulse (dev_rst_pulse),
    .dev_dma_en    (dev_dma_en),
    .dev_en_rise   (dev_en_rise),
    .dev_en_fall   (dev_en_fall),
    .csr_q         (csr_q)
);

// File: tb/test_dmac_regs.sv
`timescale 1ns/1ps
module test_dmac_regs;
    localparam int ADDR_W = 12;
    localparam int ADV_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [3:0]        bus_be = 4'hF;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              dev_irq_req = 1'b0;
    logic              dev_adv_valid = 1'b0;
    logic [ADV_W-1:0]  dev_adv_bytes = '0;
    logic              irq_out, dev_rst_pulse, dev_dma_en, dev_en_rise, dev_en_fall;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    dmac_regs #(.ADDR_W(ADDR_W), .ADV_W(ADV_W)) i_dmac_regs (.*);

    // {write data, expected control word, pulse, enable, rise, fall}
    localparam int NVEC = 7;
    localparam logic [67:0] VEC [NVEC] = '{
        {32'h0000_0000, 32'hA000_0040, 4'b0000},
        {32'h0000_0050, 32'hA000_0010, 4'b0000},
        {32'h0000_00C0, 32'hA000_00C0, 4'b1000},
        {32'hFFFF_FFFF, 32'hA1FF_FFF8, 4'b1110},
        {32'h0000_0200, 32'hA000_0200, 4'b0100},
        {32'h0000_0000, 32'hA000_0040, 4'b0001},
        {32'h8000_0000, 32'hA000_0000, 4'b0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [3:0] be, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0; bus_be = 4'hF;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R2 reset state
        bus_read(12'h000, 4'hF, rd); chk("R2 csr reset", rd, 32'hA000_0000);
        bus_read(12'h004, 4'hF, rd); chk("R2 addr reset", rd, 0);
        bus_read(12'h008, 4'hF, rd); chk("R2 count reset", rd, 0);
        bus_read(12'h00C, 4'hF, rd); chk("R2 high reset", rd, 0);
        chk("R2 outputs reset", {27'd0, irq_out, dev_rst_pulse, dev_dma_en, dev_en_rise, dev_en_fall}, 0);

        // R5 R6 R7 R8 control word rewriting table
        for (int i = 0; i < NVEC; i++) begin
            bus_write(12'h000, VEC[i][67:36], 4'hF);
            chk($sformatf("R6 pulse vec%0d", i), {31'd0, dev_rst_pulse}, {31'd0, VEC[i][3]});
            chk($sformatf("R8 en/rise/fall vec%0d", i), {29'd0, dev_dma_en, dev_en_rise, dev_en_fall},
                {29'd0, VEC[i][2:0]});
            bus_read(12'h000, 4'hF, rd);
            chk($sformatf("R5 R7 csr vec%0d", i), rd, VEC[i][35:4]);
        end
        @(negedge clk);
        chk("R6 pulse gone", {31'd0, dev_rst_pulse}, 0);

        // R1 R9 R12 aliasing and loaded flag
        bus_write(12'h034, 32'h1000_0000, 4'hF);
        bus_read(12'h004, 4'hF, rd); chk("R12 R1 addr read", rd, 32'h1000_0000);
        bus_read(12'h104, 4'hF, rd); chk("R1 addr alias", rd, 32'h1000_0000);
        bus_read(12'h010, 4'hF, rd); chk("R9 loaded set", rd, 32'hA400_0000);
        bus_write(12'h000, 32'h0, 4'hF);
        bus_read(12'h000, 4'hF, rd); chk("R9 R5 loaded kept", rd, 32'hA400_0040);
        bus_write(12'h01C, 32'h0000_00F0, 4'hF);
        bus_read(12'h00C, 4'hF, rd); chk("R1 high reg", rd, 32'h0000_00F0);

        // R10 partial accesses
        bus_write(12'h008, 32'h0000_0055, 4'hF);
        bus_write(12'h008, 32'h0000_DEAD, 4'b0011);
        bus_read(12'h008, 4'hF, rd); chk("R10 partial write ignored", rd, 32'h0000_0055);
        bus_read(12'h008, 4'b0011, rd); chk("R10 partial read zero", rd, 0);

        // R11 address advance and priority
        @(negedge clk); dev_adv_valid = 1'b1; dev_adv_bytes = 16'd8;
        @(negedge clk); dev_adv_valid = 1'b0;
        bus_read(12'h004, 4'hF, rd); chk("R11 advance", rd, 32'h1000_0008);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h004; bus_wdata = 32'h0000_2000;
        dev_adv_valid = 1'b1; dev_adv_bytes = 16'd4;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; dev_adv_valid = 1'b0;
        bus_read(12'h004, 4'hF, rd); chk("R11 write wins", rd, 32'h0000_2000);

        // R3 R4 interrupt path
        bus_write(12'h000, 32'h0000_0010, 4'hF);
        chk("R4 no req no irq", {31'd0, irq_out}, 0);
        dev_irq_req = 1'b1;
        @(negedge clk);
        chk("R4 irq asserted", {31'd0, irq_out}, 1);
        bus_read(12'h000, 4'hF, rd); chk("R3 pending set", rd, 32'hA400_0011);
        bus_write(12'h000, 32'h0000_0000, 4'hF);
        chk("R4 irq gated off", {31'd0, irq_out}, 0);
        bus_read(12'h000, 4'hF, rd); chk("R3 R5 pending kept", rd, 32'hA400_0041);
        dev_irq_req = 1'b0;
        @(negedge clk);
        bus_read(12'h000, 4'hF, rd); chk("R3 pending cleared", rd, 32'hA400_0040);

        // R2 reset after activity
        do_reset();
        bus_read(12'h000, 4'hF, rd); chk("R2 csr re-reset", rd, 32'hA000_0000);
        bus_read(12'h004, 4'hF, rd); chk("R2 addr re-reset", rd, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule